// File: doc/BRIEF.md
# Dual-Processor Handover Port

This block is a write-only control port on a bus shared by two processors, CPU A and CPU B. Only one of them may run at a time. The processor that is running writes a control byte into the port. The block keeps three bits of that byte: an interrupt-mask bit, a swap-interrupt bit and a processor-select bit. It drives a hold line into each processor; a processor runs while its hold line is low.

Each hold line is retimed in its own processor's clock domain, so a hold line only changes on that processor's rising clock edge. A handover is sequenced from the bus clock domain. The processor that is giving up the bus is held first, and its raised hold line is observed through a synchronizer. Only after that is the other processor released. Because of this order the two processors are never released together, even when the select bit is rewritten while a handover is still in progress.

After reset the select bit is 0, so CPU A is the processor that gets released.

Top module: `cpu_handover_port`

## Requirements
- R1: While reset is asserted, intMask and swapIrq are 0 and holdA and holdB are both 1. After reset, with no write, the port settles to holdA=0 and holdB=1.
- R2: On a rising busClk edge with chipSel=1 and wrStrobe=1, data bit 0 loads intMask, data bit 1 loads swapIrq and data bit 7 loads the select bit. The new intMask and swapIrq values show at the outputs after that edge.
- R3: Data bits 6 down to 2 have no effect on any output.
- R4: If chipSel or wrStrobe is 0 at a busClk edge, the latched bits keep their values.
- R5: holdA changes only at rising edges of clkA, and holdB changes only at rising edges of clkB.
- R6: holdA and holdB are never both 0. In a handover, the incoming processor's hold falls only while the outgoing processor's hold is already 1.
- R7: With select=1 the holds settle to holdA=1 and holdB=0. With select=0 they settle to holdA=0 and holdB=1. Settling takes at most 100 busClk cycles with the bench clocks.
- R8: Writing the select value that is already in effect leaves both hold lines unchanged.
- R9: If the select bit is written back before a handover completes, the holds still settle to the value written last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Clock on which chip select and write strobe are sampled |
| clkA | input | 1 | Clock of CPU A |
| clkB | input | 1 | Clock of CPU B |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSel | input | 1 | Decoded select of the port address |
| wrStrobe | input | 1 | Write strobe |
| wrData | input | 8 | Control byte being written |
| intMask | output | 1 | Latched interrupt-mask bit |
| swapIrq | output | 1 | Latched swap-interrupt bit |
| holdA | output | 1 | Hold line of CPU A (1 = held) |
| holdB | output | 1 | Hold line of CPU B (1 = held) |

## Verification
A register write and a handover already in flight can land in the same busClk cycle. The same is true of a write that reverses the select bit while the two hold synchronizers are mid-transfer. The bench provokes these cases with randomly spaced writes and by writing the select bit back one to three cycles after flipping it. It then judges the result in two ways. The first is a continuous monitor that flags any instant with both holds low, or any hold edge that is not on its own clock. The second is a settle check that compares the final holds against the select value written last.

// File: rtl/swap_port_pkg.sv
package swap_port_pkg;
  // Handover sequencer: RUN = that CPU released, PARK = waiting for its hold to be seen high
  typedef enum logic [1:0] {
    ST_RUN_A   = 2'd0,
    ST_PARK_A  = 2'd1,
    ST_RUN_B   = 2'd2,
    ST_PARK_B  = 2'd3
  } ownState_t;

  typedef struct packed {
    logic loadCfg;
    logic releaseA;
    logic releaseB;
  } swapStrobe_t;
endpackage

// File: rtl/swap_hold_retimer.sv
module swap_hold_retimer #(
  parameter int STAGES = 2
) (
  input  logic cpuClk,
  input  logic rstN,
  input  logic relReq,
  output logic hold
);
  logic [STAGES-1:0] syncChain;

  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      hold      <= 1'b1;
    end else begin
      syncChain <= {syncChain[STAGES-2:0], relReq};
      hold      <= ~syncChain[STAGES-1];
    end
  end
endmodule

// File: rtl/swap_port_ctl.sv
module swap_port_ctl
  import swap_port_pkg::*;
(
  input  logic        busClk,
  input  logic        rstN,
  input  logic        chipSel,
  input  logic        wrStrobe,
  input  logic        selBit,
  input  logic        holdASeen,
  input  logic        holdBSeen,
  output swapStrobe_t strobe
);
  ownState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN_A:  if (selBit && !holdASeen) stateNext = ST_PARK_A;
      ST_PARK_A: if (holdASeen) stateNext = selBit ? ST_RUN_B : ST_RUN_A;
      ST_RUN_B:  if (!selBit && !holdBSeen) stateNext = ST_PARK_B;
      ST_PARK_B: if (holdBSeen) stateNext = selBit ? ST_RUN_B : ST_RUN_A;
      default:   stateNext = ST_PARK_B;
    endcase
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) state <= ST_RUN_A;
    else       state <= stateNext;
  end

  assign strobe.loadCfg  = chipSel & wrStrobe;
  assign strobe.releaseA = (state == ST_RUN_A);
  assign strobe.releaseB = (state == ST_RUN_B);

  // R6: B is released only once A's hold has been observed high
  a_r6_release_b_after_a_held: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(strobe.releaseB) |-> holdASeen);
  // R6: A is released only once B's hold has been observed high
  a_r6_release_a_after_b_held: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(strobe.releaseA) |-> holdBSeen);
endmodule

// File: rtl/swap_port_dp.sv
module swap_port_dp
  import swap_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MASK_BIT    = 0,
  parameter int IRQ_BIT     = 1,
  parameter int SEL_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  swapStrobe_t       strobe,
  output logic              intMask,
  output logic              swapIrq,
  output logic              selBit,
  output logic              holdASeen,
  output logic              holdBSeen,
  output logic              holdA,
  output logic              holdB
);
  localparam int NUM_CPU = 2;

  logic [NUM_CPU-1:0] cpuClk, relReq, holdVec, seenVec;
  logic               unusedDataBits;

  assign unusedDataBits = ^wrData;

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      intMask <= 1'b0;
      swapIrq <= 1'b0;
      selBit  <= 1'b0;
    end else if (strobe.loadCfg) begin
      intMask <= wrData[MASK_BIT];
      swapIrq <= wrData[IRQ_BIT];
      selBit  <= wrData[SEL_BIT];
    end
  end

  assign cpuClk = {clkB, clkA};
  assign relReq = {strobe.releaseB, strobe.releaseA};

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [SYNC_STAGES-1:0] seenChain;

    swap_hold_retimer #(.STAGES(SYNC_STAGES)) u_retimer (
      .cpuClk (cpuClk[c]),
      .rstN   (rstN),
      .relReq (relReq[c]),
      .hold   (holdVec[c])
    );

    always_ff @(posedge busClk or negedge rstN) begin
      if (!rstN) seenChain <= '1;
      else       seenChain <= {seenChain[SYNC_STAGES-2:0], holdVec[c]};
    end
    assign seenVec[c] = seenChain[SYNC_STAGES-1];
  end

  assign holdA     = holdVec[0];
  assign holdB     = holdVec[1];
  assign holdASeen = seenVec[0];
  assign holdBSeen = seenVec[1];

  a_r2_load_fields: assert property (@(posedge busClk) disable iff (!rstN)
    strobe.loadCfg |=> (intMask == $past(wrData[MASK_BIT]) &&
                        swapIrq == $past(wrData[IRQ_BIT]) &&
                        selBit  == $past(wrData[SEL_BIT])));
  a_r4_keep_fields: assert property (@(posedge busClk) disable iff (!rstN)
    !strobe.loadCfg |=> $stable({intMask, swapIrq, selBit}));
  a_r6_not_both_low_a: assert property (@(posedge clkA) disable iff (!rstN)
    (holdA || holdB));
  a_r6_not_both_low_b: assert property (@(posedge clkB) disable iff (!rstN)
    (holdA || holdB));
  a_r6_b_falls_a_held: assert property (@(posedge clkB) disable iff (!rstN)
    $fell(holdB) |-> holdA);
  a_r6_a_falls_b_held: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(holdA) |-> holdB);
endmodule

// File: rtl/cpu_handover_port.sv
module cpu_handover_port
  import swap_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MASK_BIT    = 0,
  parameter int IRQ_BIT     = 1,
  parameter int SEL_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              intMask,
  output logic              swapIrq,
  output logic              holdA,
  output logic              holdB
);
  swapStrobe_t strobe;
  logic        selBit, holdASeen, holdBSeen;

  swap_port_ctl u_ctl (
    .busClk    (busClk),
    .rstN      (rstN),
    .chipSel   (chipSel),
    .wrStrobe  (wrStrobe),
    .selBit    (selBit),
    .holdASeen (holdASeen),
    .holdBSeen (holdBSeen),
    .strobe    (strobe)
  );

  swap_port_dp #(
    .DATA_W      (DATA_W),
    .MASK_BIT    (MASK_BIT),
    .IRQ_BIT     (IRQ_BIT),
    .SEL_BIT     (SEL_BIT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .busClk    (busClk),
    .clkA      (clkA),
    .clkB      (clkB),
    .rstN      (rstN),
    .wrData    (wrData),
    .strobe    (strobe),
    .intMask   (intMask),
    .swapIrq   (swapIrq),
    .selBit    (selBit),
    .holdASeen (holdASeen),
    .holdBSeen (holdBSeen),
    .holdA     (holdA),
    .holdB     (holdB)
  );
endmodule

// File: tb/cpu_handover_port_bench.sv
module cpu_handover_port_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int SETTLE_LIMIT = 100;

  logic busClk = 0, clkA = 0, clkB = 0, rstN = 0;
  logic chipSel = 0, wrStrobe = 0;
  logic [7:0] wrData = '0;
  logic intMask, swapIrq, holdA, holdB;

  int checkCount = 0, failCount = 0;
  int bothLowCount = 0, edgeErrCount = 0;
  bit modelMask = 0, modelIrq = 0, modelSel = 0;
  time lastEdgeA = 0, lastEdgeB = 0;

  cpu_handover_port u_cpu_handover_port (
    .busClk(busClk), .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .chipSel(chipSel), .wrStrobe(wrStrobe), .wrData(wrData),
    .intMask(intMask), .swapIrq(swapIrq), .holdA(holdA), .holdB(holdB)
  );

  always #(CLK_PERIOD/2) busClk = ~busClk;
  initial begin #3; forever #7 clkA = ~clkA; end
  initial begin #5; forever #11 clkB = ~clkB; end

  always @(posedge clkA) lastEdgeA = $time;
  always @(posedge clkB) lastEdgeB = $time;

  // R5 monitors: holds move only on their own rising clock edge
  always @(holdA) if (rstN && $time != lastEdgeA) edgeErrCount++;
  always @(holdB) if (rstN && $time != lastEdgeB) edgeErrCount++;
  // R6 monitor: never both released
  always @(negedge busClk) if (rstN && !holdA && !holdB) bothLowCount++;

  function automatic bit expHoldA(bit sel); return sel; endfunction
  function automatic bit expHoldB(bit sel); return !sel; endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic busCycle(bit cs, bit wr, logic [7:0] d);
    @(negedge busClk);
    chipSel = cs; wrStrobe = wr; wrData = d;
    if (cs && wr) begin modelMask = d[0]; modelIrq = d[1]; modelSel = d[7]; end
    @(negedge busClk);
    chipSel = 0; wrStrobe = 0; wrData = $urandom;
  endtask

  task automatic checkFields(string req);
    check(intMask == modelMask, req, "intMask", intMask, modelMask);
    check(swapIrq == modelIrq, req, "swapIrq", swapIrq, modelIrq);
  endtask

  task automatic waitSettle(string req);
    int n = 0;
    while (n < SETTLE_LIMIT && !(holdA == expHoldA(modelSel) && holdB == expHoldB(modelSel))) begin
      @(negedge busClk); n++;
    end
    check(holdA == expHoldA(modelSel), req, "holdA settled", holdA, expHoldA(modelSel));
    check(holdB == expHoldB(modelSel), req, "holdB settled", holdB, expHoldB(modelSel));
  endtask

  task automatic finishRun();
    check(bothLowCount == 0, "R6", "both-low samples", bothLowCount, 0);
    check(edgeErrCount == 0, "R5", "off-edge hold changes", edgeErrCount, 0);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++; checkCount++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge busClk);
    // R1: reset state
    check(intMask == 0, "R1", "intMask in reset", intMask, 0);
    check(swapIrq == 0, "R1", "swapIrq in reset", swapIrq, 0);
    check(holdA == 1, "R1", "holdA in reset", holdA, 1);
    check(holdB == 1, "R1", "holdB in reset", holdB, 1);
    rstN = 1;
    waitSettle("R1");

    // R2: full write of all three bits
    busCycle(1, 1, 8'h83);
    checkFields("R2");
    waitSettle("R2");
    // R8: rewrite same select, holds must not move
    busCycle(1, 1, 8'h80);
    checkFields("R8");
    begin
      bit moved = 0;
      repeat (50) begin
        @(negedge busClk);
        if (holdA != 1 || holdB != 0) moved = 1;
      end
      check(!moved, "R8", "holds moved on same-select write", moved, 0);
    end
    // R4: strobe without select and select without strobe
    busCycle(1, 0, 8'h03);
    checkFields("R4");
    busCycle(0, 1, 8'h03);
    checkFields("R4");
    check(intMask == 0 && swapIrq == 0, "R4", "fields untouched", {intMask, swapIrq}, 0);
    // R3: only the ignored bits set
    busCycle(1, 1, 8'h7C);
    check(intMask == 0 && swapIrq == 0, "R3", "ignored bits", {intMask, swapIrq}, 0);
    waitSettle("R3");
    // R9: reverse the select before the handover finishes
    for (int k = 1; k <= 3; k++) begin
      busCycle(1, 1, 8'h80);
      repeat (k) @(negedge busClk);
      busCycle(1, 1, 8'h00);
      waitSettle("R9");
      busCycle(1, 1, 8'h00);
      busCycle(1, 1, 8'h80);
      repeat (k) @(negedge busClk);
      busCycle(1, 1, 8'h00);
      busCycle(1, 1, 8'h80);
      waitSettle("R9");
    end
    // R2/R4/R7: random writes mixed with gaps
    for (int i = 0; i < 60; i++) begin
      busCycle($urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom));
      checkFields("R2");
      repeat ($urandom_range(0, 6)) @(negedge busClk);
      if (i % 10 == 9) waitSettle("R7");
    end
    waitSettle("R7");
    finishRun();
  end
endmodule